// File: doc/BRIEF.md
# Variable Page Size Address Translation Buffer

This block is a fully associative translation buffer that turns a virtual address into a real address for both instruction and data fetches. Software owns every entry. It writes a whole entry at an index it picks, and it may wipe the whole buffer with a single flush. The hardware never picks a victim and never walks page tables.

Each entry has its own page size, chosen from eight sizes between 1 KB and 256 MB, and entries of different sizes may be valid together. A lookup compares every entry at once. Each comparison ignores the address bits that fall inside that entry's page. The result is available in the same cycle as the lookup. It gives a hit flag, the real address, eight storage attribute bits, a protection fault flag and a flag for overlapping matches. Read, write and execute rights are held separately for user and supervisor state.

Top module: `vpt_xlate`

## Requirements
- R1: After reset no entry is valid, so every lookup misses.
- R2: When `wrEn` is high at a rising clock edge and `flushAll` is low, the entry at `wrIdx` is loaded with the presented fields and becomes valid. No other entry changes.
- R3: Size code c gives a page offset of 10, 12, 14, 16, 18, 20, 24 or 28 bits for c = 0..7. `wrPage` holds VA[31:10] of the page. An entry matches when it is valid and VA bits above its offset equal the corresponding bits of its stored page number. Stored page bits that fall inside the offset are ignored.
- R4: On a hit, the real address takes the bits above the entry's offset from its stored frame number (frame number = PA[31:10]) and the offset bits from the virtual address.
- R5: The lookup outputs follow the lookup inputs combinationally, in the same cycle, with no clock edge in between.
- R6: When two or more valid entries match, the lowest-indexed one supplies the result and `lkMulti` is high. Otherwise `lkMulti` is low.
- R7: Permission bits are: bit0 user read, bit1 user write, bit2 user execute, bit3 supervisor read, bit4 supervisor write, bit5 supervisor execute. `lkAccess` is 0 for read, 1 for write, 2 for execute and 3 for reserved. `lkSuper` high selects the supervisor bits. `lkFault` is high on a hit when the selected bit is clear, and always when the access code is 3.
- R8: A faulting hit still reports `lkHit`, the translated `lkPa` and `lkAttr`.
- R9: On a hit `lkAttr` is the stored attribute byte. Its bits are: bit0 cacheable, bit1 write-through, bit2 little-endian, bit3 guarded, bits 7:4 user-defined.
- R10: `flushAll` high at a rising edge invalidates every entry. A write in that same cycle leaves its entry invalid.
- R11: On a miss, `lkPa` and `lkAttr` are zero, and `lkFault` and `lkMulti` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushAll | input | 1 | Invalidate all entries at the clock edge |
| wrEn | input | 1 | Load one entry at the clock edge |
| wrIdx | input | IDX_W | Entry index to load |
| wrPage | input | ADDR_W-10 | Virtual page number, VA[31:10] |
| wrSize | input | 3 | Page size code |
| wrFrame | input | ADDR_W-10 | Real frame number, PA[31:10] |
| wrAttr | input | 8 | Storage attributes |
| wrPerm | input | 6 | Access permission bits |
| lkVa | input | ADDR_W | Virtual address to translate |
| lkAccess | input | 2 | Access type |
| lkSuper | input | 1 | Supervisor privilege |
| lkHit | output | 1 | A valid entry matched |
| lkPa | output | ADDR_W | Translated real address |
| lkAttr | output | 8 | Attributes of the selected entry |
| lkFault | output | 1 | Protection fault |
| lkMulti | output | 1 | More than one entry matched |

## Verification
The bench builds the block with ENTRIES = 8 and a 32-bit address. Eight entries are enough to give every size code its own entry and its own 256 MB region. This makes it possible to probe every page edge, including the addresses one below and one above each page, alongside random addresses. With the small array, all 64 permission patterns can be swept against every access code and both privilege levels. Overlapping large and small pages can be placed in both index orders to exercise the priority rule.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  localparam int MinOff = 10;
  localparam int AttrW  = 8;
  localparam int PermW  = 6;

  typedef struct packed {
    logic [3:0] user;
    logic       guarded;
    logic       littleEnd;
    logic       writeThru;
    logic       cacheable;
  } attr_t;

  typedef struct packed {
    logic clearAll;
    logic load;
  } strobe_t;

  function automatic int offBits(input logic [2:0] code);
    case (code)
      3'd6:    offBits = 24;
      3'd7:    offBits = 28;
      default: offBits = MinOff + 2 * int'(code);
    endcase
  endfunction

endpackage

// File: rtl/vpt_ctrl.sv
module vpt_ctrl
  import vpt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushAll,
  input  logic             wrEn,
  input  logic [1:0]       lkAccess,
  input  logic             lkSuper,
  output strobe_t          stb,
  output logic [PermW-1:0] needPerm
);

  always_comb begin
    stb.clearAll = flushAll;
    stb.load     = wrEn & ~flushAll;
  end

  always_comb begin
    needPerm = '0;
    case (lkAccess)
      2'd0: needPerm[lkSuper ? 3 : 0] = 1'b1;
      2'd1: needPerm[lkSuper ? 4 : 1] = 1'b1;
      2'd2: needPerm[lkSuper ? 5 : 2] = 1'b1;
      default: needPerm = '0;
    endcase
  end

  assert_perm_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(needPerm));

  assert_perm_selected_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lkAccess != 2'd3) |-> ($countones(needPerm) == 1));

  assert_flush_beats_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> !stb.load);

endmodule

// File: rtl/vpt_datapath.sv
module vpt_datapath
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PAGE_W = ADDR_W - MinOff
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PAGE_W-1:0] wrPage,
  input  logic [2:0]        wrSize,
  input  logic [PAGE_W-1:0] wrFrame,
  input  logic [AttrW-1:0]  wrAttr,
  input  logic [PermW-1:0]  wrPerm,
  input  logic [ADDR_W-1:0] lkVa,
  input  logic [PermW-1:0]  needPerm,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPa,
  output logic [AttrW-1:0]  lkAttr,
  output logic              lkFault,
  output logic              lkMulti
);

  function automatic logic [PAGE_W-1:0] pageMask(input logic [2:0] code);
    logic [PAGE_W-1:0] m;
    m = '1;
    return m << (offBits(code) - MinOff);
  endfunction

  logic [ENTRIES-1:0] validQ;
  logic [PAGE_W-1:0]  pageQ  [ENTRIES];
  logic [2:0]         sizeQ  [ENTRIES];
  logic [PAGE_W-1:0]  frameQ [ENTRIES];
  logic [AttrW-1:0]   attrQ  [ENTRIES];
  logic [PermW-1:0]   permQ  [ENTRIES];

  logic [PAGE_W-1:0]  entMask [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [IDX_W-1:0]   selIdx;
  logic [PAGE_W-1:0]  vaPage;
  logic [PAGE_W-1:0]  selMask;
  logic [PAGE_W-1:0]  paPage;

  always_ff @(posedge clk) begin
    if (!rstN)             validQ <= '0;
    else if (stb.clearAll) validQ <= '0;
    else if (stb.load)     validQ[wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.load) begin
      pageQ[wrIdx]  <= wrPage;
      sizeQ[wrIdx]  <= wrSize;
      frameQ[wrIdx] <= wrFrame;
      attrQ[wrIdx]  <= wrAttr;
      permQ[wrIdx]  <= wrPerm;
    end
  end

  assign vaPage = lkVa[ADDR_W-1:MinOff];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign entMask[g]  = pageMask(sizeQ[g]);
    assign matchVec[g] = validQ[g] && (((vaPage ^ pageQ[g]) & entMask[g]) == '0);
  end

  always_comb begin
    selIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IDX_W'(i);
    end
  end

  assign selMask = entMask[selIdx];
  assign paPage  = (frameQ[selIdx] & selMask) | (vaPage & ~selMask);

  always_comb begin
    lkHit   = |matchVec;
    lkMulti = |(matchVec & (matchVec - ENTRIES'(1)));
    lkPa    = lkHit ? {paPage, lkVa[MinOff-1:0]} : '0;
    lkAttr  = lkHit ? attrQ[selIdx] : '0;
    lkFault = lkHit && ((permQ[selIdx] & needPerm) == '0);
  end

  assert_miss_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPa == '0 && lkAttr == '0 && !lkFault && !lkMulti));

  assert_multi_needs_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    lkMulti |-> lkHit);

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (validQ == '0));

  assert_load_sets_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> validQ[$past(wrIdx)]);

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkPa[MinOff-1:0] == lkVa[MinOff-1:0]));

endmodule

// File: rtl/vpt_xlate.sv
module vpt_xlate
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PAGE_W = ADDR_W - MinOff
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushAll,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [PAGE_W-1:0] wrPage,
  input  logic [2:0]        wrSize,
  input  logic [PAGE_W-1:0] wrFrame,
  input  logic [7:0]        wrAttr,
  input  logic [5:0]        wrPerm,
  input  logic [ADDR_W-1:0] lkVa,
  input  logic [1:0]        lkAccess,
  input  logic              lkSuper,
  output logic              lkHit,
  output logic [ADDR_W-1:0] lkPa,
  output logic [7:0]        lkAttr,
  output logic              lkFault,
  output logic              lkMulti
);

  strobe_t          stb;
  logic [PermW-1:0] needPerm;

  vpt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flushAll (flushAll),
    .wrEn     (wrEn),
    .lkAccess (lkAccess),
    .lkSuper  (lkSuper),
    .stb      (stb),
    .needPerm (needPerm)
  );

  vpt_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrIdx    (wrIdx),
    .wrPage   (wrPage),
    .wrSize   (wrSize),
    .wrFrame  (wrFrame),
    .wrAttr   (wrAttr),
    .wrPerm   (wrPerm),
    .lkVa     (lkVa),
    .needPerm (needPerm),
    .lkHit    (lkHit),
    .lkPa     (lkPa),
    .lkAttr   (lkAttr),
    .lkFault  (lkFault),
    .lkMulti  (lkMulti)
  );

endmodule

// File: tb/sim_vpt_xlate.sv
`timescale 1ns/1ps
module sim_vpt_xlate;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flushAll = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [21:0] wrPage = '0;
  logic [2:0]  wrSize = '0;
  logic [21:0] wrFrame = '0;
  logic [7:0]  wrAttr = '0;
  logic [5:0]  wrPerm = '0;
  logic [31:0] lkVa = '0;
  logic [1:0]  lkAccess = '0;
  logic        lkSuper = 1'b0;
  logic        lkHit, lkFault, lkMulti;
  logic [31:0] lkPa;
  logic [7:0]  lkAttr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic        mValid [N];
  logic [21:0] mPage  [N];
  logic [2:0]  mSize  [N];
  logic [21:0] mFrame [N];
  logic [7:0]  mAttr  [N];
  logic [5:0]  mPerm  [N];

  always #4 clk = ~clk;

  vpt_xlate #(.ENTRIES(N), .ADDR_W(32)) u0 (.*);

  function automatic int offOf(input int c);
    return (c == 6) ? 24 : (c == 7) ? 28 : 10 + 2 * c;
  endfunction

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s va=%h actual=%h expected=%h", req, lkVa, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [21:0] page, input int size,
                    input logic [21:0] frame, input logic [7:0] attr,
                    input logic [5:0] perm, input bit withFlush);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'(idx); wrPage = page; wrSize = 3'(size);
    wrFrame = frame; wrAttr = attr; wrPerm = perm; flushAll = withFlush;
    @(negedge clk);
    wrEn = 1'b0; flushAll = 1'b0;
    if (withFlush) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else begin
      mValid[idx] = 1'b1; mPage[idx] = page; mSize[idx] = 3'(size);
      mFrame[idx] = frame; mAttr[idx] = attr; mPerm[idx] = perm;
    end
  endtask

  task automatic flush();
    @(negedge clk);
    flushAll = 1'b1;
    @(negedge clk);
    flushAll = 1'b0;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
  endtask

  // Lookup is combinational (R5): inputs driven and checked inside one low phase.
  task automatic look(input logic [31:0] va, input int acc, input bit sup, input string tag);
    bit eHit, eMulti, eFault;
    int eIdx;
    logic [31:0] m, ePa;
    logic [7:0] eAttr;
    eHit = 0; eMulti = 0; eIdx = 0; eFault = 0; ePa = '0; eAttr = '0;
    for (int i = 0; i < N; i++) begin
      if (mValid[i]) begin
        m = 32'hFFFF_FFFF << offOf(int'(mSize[i]));
        if ((va & m) == ({mPage[i], 10'b0} & m)) begin
          if (eHit) eMulti = 1; else eIdx = i;
          eHit = 1;
        end
      end
    end
    if (eHit) begin
      m = 32'hFFFF_FFFF << offOf(int'(mSize[eIdx]));
      ePa = ({mFrame[eIdx], 10'b0} & m) | (va & ~m);
      eAttr = mAttr[eIdx];
      eFault = (acc == 3) || !mPerm[eIdx][(sup ? 3 : 0) + acc];
    end
    @(negedge clk);
    lkVa = va; lkAccess = 2'(acc); lkSuper = sup;
    #1;
    cmp({tag, " R3 hit"}, {31'b0, lkHit}, {31'b0, eHit});
    cmp({tag, " R4 R6 pa"}, lkPa, ePa);
    cmp({tag, " R9 attr"}, {24'b0, lkAttr}, {24'b0, eAttr});
    cmp({tag, " R7 R8 fault"}, {31'b0, lkFault}, {31'b0, eFault});
    cmp({tag, " R6 multi"}, {31'b0, lkMulti}, {31'b0, eMulti});
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 and R11: empty after reset.
    look(32'h0000_0000, 0, 0, "R1 reset");
    look(32'hFFFF_FFFF, 2, 1, "R1 reset");

    // R2 R3 R4 R9: one entry per size code, each in its own 256 MB region.
    for (int c = 0; c < 8; c++) begin
      logic [31:0] base;
      logic [21:0] junk;
      int off;
      off = offOf(c);
      base = (c == 7) ? (32'(8 + c) << 28) : ((32'(8 + c) << 28) | (32'd3 << off));
      junk = 22'h15555 & 22'((32'd1 << (off - 10)) - 1);
      wr(c, base[31:10] | junk, c, 22'($urandom) , 8'(8'h11 * (c + 1)), 6'h3F, 0);
    end
    for (int c = 0; c < 8; c++) begin
      logic [31:0] base, sz;
      int off;
      off = offOf(c);
      sz = 32'd1 << off;
      base = (c == 7) ? (32'(8 + c) << 28) : ((32'(8 + c) << 28) | (32'd3 << off));
      look(base, 0, 0, "R3 base");
      look(base + sz - 1, 1, 1, "R3 last");
      look(base + sz, 0, 1, "R3 above");
      look(base - 1, 2, 0, "R3 below");
      for (int k = 0; k < 12; k++) look(base + ($urandom % sz), 0, 0, "R4 inside");
      for (int k = 0; k < 6; k++) look({4'(8 + c), 28'($urandom)}, 0, 1, "R3 region");
    end

    // R7 R8: every permission pattern against every access code and privilege.
    for (int p = 0; p < 64; p++) begin
      wr(0, 22'h20_0000 | 22'h123, 0, 22'h2A_BCDE, 8'hA5, 6'(p), 0);
      for (int a = 0; a < 4; a++) begin
        look({22'h20_0123, 10'h3C7}, a, 0, "R7 user");
        look({22'h20_0123, 10'h011}, a, 1, "R7 super");
      end
    end

    // R6: overlap, small page at lower index.
    wr(5, 22'h0C_0000, 7, 22'h10_0000, 8'h0F, 6'h3F, 0);
    wr(2, 22'h0C_1234, 1, 22'h3F_FFF0, 8'hF0, 6'h01, 0);
    look({22'h0C_1234, 10'h200}, 0, 0, "R6 small wins");
    look({22'h0C_2000, 10'h000}, 0, 0, "R6 large only");
    // R6: overlap, large page at lower index.
    wr(1, 22'h0C_0000, 7, 22'h24_0000, 8'h3C, 6'h08, 0);
    look({22'h0C_1234, 10'h200}, 0, 1, "R6 large wins");

    // R10: flush, then flush racing a write.
    flush();
    look({22'h0C_1234, 10'h200}, 0, 0, "R10 flushed");
    look(32'hF000_0000, 0, 0, "R10 flushed");
    wr(4, 22'h01_0000, 3, 22'h02_0000, 8'h77, 6'h3F, 1);
    look({22'h01_0000, 10'h000}, 0, 0, "R10 write lost");
    wr(4, 22'h01_0000, 3, 22'h02_0000, 8'h77, 6'h3F, 0);
    look({22'h01_0000, 10'h155}, 1, 0, "R2 write after flush");
    look({22'h01_0040, 10'h000}, 1, 0, "R2 next page");

    // R1: reset clears the buffer again.
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    look({22'h01_0000, 10'h155}, 0, 0, "R1 rereset");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule